// File: doc/BRIEF.md
# Programmable Chip Select Window Decoder

This block maps a 24-bit bus address onto one of eight chip-select lines. Chip selects 1 to 7 each own a programmable address window. A window is described by a base address, a size code and an enable bit, all written through a register port. The window size is a power of two, from 4 KB up to 8 MB. Chip select 0 has no window. It catches every address that no enabled window claims.

The decoder produces three things. The first is the index of the winning window, which the bus sequencer uses to pick that window's timing and function settings. The second is a set of active-low chip-select pins. The third is a copy of the upper address lines A16 to A23. All of these are registered, so they change cleanly at a clock edge. A pin-configuration write sets how many chip-select pins and how many upper address pins are actually driven. The remaining pins stay inactive.

Top module: `cs_window_decoder`

## Requirements
- R1: A window with size code s in 0..11 spans 4 KB << s bytes. It matches an address when address bits [23:12+s] equal the same bits of its base.
- R2: A window whose size code is 12, 13, 14 or 15 never matches.
- R3: A window whose enable bit is 0 never selects its chip select.
- R4: When several enabled windows match, the one with the lowest index wins.
- R5: When no enabled window matches, index 0 is selected.
- R6: cs_no_o is active low with at most one bit low. Outputs reflect the address and configuration present before the previous rising edge, one cycle of latency.
- R7: With cs_cnt_i latched as n in 0..8, only chip-select pins with index below n may go low. Values 9..15 act as 0. The selected index on cfg_idx_o is reported in all cases.
- R8: With hi_cnt_i latched as m in 0..8, addr_hi_o bit j carries address bit 16+j for j below m and is 0 otherwise. Values 9..15 act as 0.
- R9: A window write with win_we_i high stores win_wdata_i into window win_sel_i, using the layout enable = bit 0, size code = bits [4:1], base = bits [16:5] (address bits 23..12). A pin write with pin_we_i high latches cs_cnt_i and hi_cnt_i. Each takes effect on the output one edge after it is stored.
- R10: While reset is asserted, all windows are disabled, both pin counts are 8, cs_no_o is all ones, and cfg_idx_o and addr_hi_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 24 | Bus address to decode |
| win_we_i | input | 1 | Window register write strobe |
| win_sel_i | input | 3 | Window index for the write (1..7) |
| win_wdata_i | input | 17 | Window data: enable, size code, base |
| pin_we_i | input | 1 | Pin-count write strobe |
| cs_cnt_i | input | 4 | Number of driven chip-select pins |
| hi_cnt_i | input | 4 | Number of driven upper address pins |
| cs_no_o | output | 8 | Chip selects, active low, registered |
| cfg_idx_o | output | 3 | Selected window / configuration index |
| addr_hi_o | output | 8 | Upper address pins A16..A23, gated |

## Verification
The decoder is tried with directed addresses placed on the last and first byte of a window, so an off-by-one in the size boundary is caught. Further directed cases cover windows with the smallest and largest legal size, reserved size codes, and disabled windows that would otherwise match. Overlapping windows tell a lowest-index priority apart from any other order. Pin counts of 0, partial values and reserved values separate pin gating from selection. The random phase mixes window rewrites with addresses aimed inside and outside programmed windows, so that matches, misses and overlaps all occur.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;
  localparam int ADDR_W   = 24;
  localparam int PAGE_W   = 12;  // 4 KB granule
  localparam int SIZE_W   = 4;
  localparam int MAX_SIZE = 11;  // 8 MB
  localparam int CNT_W    = 4;
  localparam int HI_W     = 8;
  localparam int TAG_W    = ADDR_W - PAGE_W;
  localparam int CFG_W    = TAG_W + SIZE_W + 1;

  typedef struct packed {
    logic [TAG_W-1:0]  base;
    logic [SIZE_W-1:0] size;
    logic              en;
  } win_cfg_t;

  // Tag bits that take part in the compare for a given size code
  function automatic logic [TAG_W-1:0] tag_mask(input logic [SIZE_W-1:0] s);
    logic [TAG_W-1:0] m;
    for (int i = 0; i < TAG_W; i++) m[i] = (i >= int'(s));
    return m;
  endfunction
endpackage

// File: rtl/cs_win_regs.sv
module cs_win_regs
  import cs_dec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  win_cfg_t         wdata_i,
  output win_cfg_t         cfg_o [NUM_CS]
);
  assign cfg_o[0] = '0;  // default select owns no window

  for (genvar k = 1; k < NUM_CS; k++) begin : g_win
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                              cfg_o[k] <= '0;
      else if (we_i && sel_i == SEL_W'(k))      cfg_o[k] <= wdata_i;
    end
  end
endmodule

// File: rtl/cs_win_match.sv
module cs_win_match
  import cs_dec_pkg::*;
(
  input  logic [TAG_W-1:0] tag_i,
  input  win_cfg_t         cfg_i,
  output logic             hit_o
);
  logic legal;
  logic same;

  assign legal = (cfg_i.size <= SIZE_W'(MAX_SIZE));
  assign same  = (((tag_i ^ cfg_i.base) & tag_mask(cfg_i.size)) == '0);
  assign hit_o = cfg_i.en && legal && same;
endmodule

// File: rtl/cs_prio_sel.sv
module cs_prio_sel #(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic [NUM_CS-1:0] hit_i,
  output logic [SEL_W-1:0]  sel_o
);
  // Scan downward so the lowest hit is written last
  always_comb begin
    sel_o = '0;
    for (int k = NUM_CS - 1; k >= 1; k--) begin
      if (hit_i[k]) sel_o = SEL_W'(k);
    end
  end
endmodule

// File: rtl/cs_out_drive.sv
module cs_out_drive
  import cs_dec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              pin_we_i,
  input  logic [CNT_W-1:0]  cs_cnt_i,
  input  logic [CNT_W-1:0]  hi_cnt_i,
  output logic [NUM_CS-1:0] cs_no_o,
  output logic [SEL_W-1:0]  cfg_idx_o,
  output logic [HI_W-1:0]   addr_hi_o
);
  logic [CNT_W-1:0] cs_cnt_q, hi_cnt_q;
  logic [CNT_W-1:0] cs_eff, hi_eff;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_cnt_q <= CNT_W'(NUM_CS);
      hi_cnt_q <= CNT_W'(HI_W);
    end else if (pin_we_i) begin
      cs_cnt_q <= cs_cnt_i;
      hi_cnt_q <= hi_cnt_i;
    end
  end

  // Reserved counts drive no pins
  assign cs_eff = (cs_cnt_q > CNT_W'(NUM_CS)) ? '0 : cs_cnt_q;
  assign hi_eff = (hi_cnt_q > CNT_W'(HI_W))   ? '0 : hi_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_idx_o <= '0;
    else         cfg_idx_o <= sel_i;
  end

  for (genvar k = 0; k < NUM_CS; k++) begin : g_cs
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cs_no_o[k] <= 1'b1;
      else         cs_no_o[k] <= !((sel_i == SEL_W'(k)) && (CNT_W'(k) < cs_eff));
    end
  end

  for (genvar j = 0; j < HI_W; j++) begin : g_hi
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) addr_hi_o[j] <= 1'b0;
      else         addr_hi_o[j] <= addr_hi_i[j] && (CNT_W'(j) < hi_eff);
    end
  end

  a_r6_one_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_no_o));
  a_r7_no_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_eff == '0) |=> (cs_no_o == '1));
  a_r7_pin_matches_idx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_no_o != '1) |-> (cs_no_o[cfg_idx_o] == 1'b0));
  a_r8_no_hi_pins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_eff == '0) |=> (addr_hi_o == '0));
endmodule

// File: rtl/cs_window_decoder.sv
module cs_window_decoder
  import cs_dec_pkg::*;
#(
  parameter int NUM_CS = 8,
  parameter int SEL_W  = $clog2(NUM_CS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              win_we_i,
  input  logic [SEL_W-1:0]  win_sel_i,
  input  logic [CFG_W-1:0]  win_wdata_i,
  input  logic              pin_we_i,
  input  logic [CNT_W-1:0]  cs_cnt_i,
  input  logic [CNT_W-1:0]  hi_cnt_i,
  output logic [NUM_CS-1:0] cs_no_o,
  output logic [SEL_W-1:0]  cfg_idx_o,
  output logic [HI_W-1:0]   addr_hi_o
);
  win_cfg_t          win_q [NUM_CS];
  logic [NUM_CS-1:0] hit;
  logic [SEL_W-1:0]  sel;
  logic [TAG_W-1:0]  tag;

  assign tag = addr_i[ADDR_W-1:PAGE_W];

  cs_win_regs #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (win_we_i),
    .sel_i   (win_sel_i),
    .wdata_i (win_cfg_t'(win_wdata_i)),
    .cfg_o   (win_q)
  );

  assign hit[0] = 1'b0;
  for (genvar k = 1; k < NUM_CS; k++) begin : g_match
    cs_win_match i_match (
      .tag_i (tag),
      .cfg_i (win_q[k]),
      .hit_o (hit[k])
    );
  end

  cs_prio_sel #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_prio (
    .hit_i (hit),
    .sel_o (sel)
  );

  cs_out_drive #(.NUM_CS(NUM_CS), .SEL_W(SEL_W)) i_out (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (sel),
    .addr_hi_i (addr_i[ADDR_W-1:ADDR_W-HI_W]),
    .pin_we_i  (pin_we_i),
    .cs_cnt_i  (cs_cnt_i),
    .hi_cnt_i  (hi_cnt_i),
    .cs_no_o   (cs_no_o),
    .cfg_idx_o (cfg_idx_o),
    .addr_hi_o (addr_hi_o)
  );

  a_r2_sel_size_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel != '0) |-> (win_q[sel].size <= SIZE_W'(MAX_SIZE)));
  a_r3_sel_enabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel != '0) |-> win_q[sel].en);
  a_r4_lowest_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit & ((NUM_CS'(1) << sel) - NUM_CS'(1))) == '0);
  a_r5_default_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit == '0) |=> (cfg_idx_o == '0));
endmodule

// File: tb/test_cs_window_decoder.sv
`timescale 1ns/1ps
module test_cs_window_decoder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] addr = '0;
  logic        win_we = 1'b0;
  logic [2:0]  win_sel = '0;
  logic [16:0] win_wdata = '0;
  logic        pin_we = 1'b0;
  logic [3:0]  cs_cnt = 4'd8, hi_cnt = 4'd8;
  logic [7:0]  cs_n;
  logic [2:0]  cfg_idx;
  logic [7:0]  addr_hi;

  int tests = 0, fails = 0;

  logic        m_en   [8];
  int          m_size [8];
  logic [11:0] m_base [8];
  int          m_cs_cnt = 8, m_hi_cnt = 8;
  logic [23:0] cur_addr = '0;
  logic [7:0]  prev_cs;
  logic [2:0]  prev_idx;
  logic [7:0]  prev_hi;

  always #5 clk = ~clk;

  cs_window_decoder i_cs_window_decoder (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr),
    .win_we_i(win_we), .win_sel_i(win_sel), .win_wdata_i(win_wdata),
    .pin_we_i(pin_we), .cs_cnt_i(cs_cnt), .hi_cnt_i(hi_cnt),
    .cs_no_o(cs_n), .cfg_idx_o(cfg_idx), .addr_hi_o(addr_hi)
  );

  function automatic int exp_idx(logic [23:0] a);
    for (int k = 1; k < 8; k++) begin
      if (m_en[k] && m_size[k] <= 11 &&
          ((a[23:12] >> m_size[k]) == (m_base[k] >> m_size[k]))) return k;
    end
    return 0;
  endfunction

  function automatic logic [7:0] exp_cs(int idx);
    int eff;
    eff = (m_cs_cnt > 8) ? 0 : m_cs_cnt;
    return (idx < eff) ? ~(8'b1 << idx) : 8'hFF;
  endfunction

  function automatic logic [7:0] exp_hi(logic [23:0] a);
    int eff;
    logic [8:0] msk;
    eff = (m_hi_cnt > 8) ? 0 : m_hi_cnt;
    msk = (9'h1 << eff) - 9'h1;
    return a[23:16] & msk[7:0];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic set_prev();
    prev_idx = 3'(exp_idx(cur_addr));
    prev_cs  = exp_cs(exp_idx(cur_addr));
    prev_hi  = exp_hi(cur_addr);
  endtask

  // R9: window write, layout en=bit0, size=[4:1], base=[16:5]
  task automatic wr_win(int k, logic [11:0] base, int size, logic en);
    @(negedge clk);
    win_we = 1'b1; win_sel = 3'(k);
    win_wdata = {base, 4'(size), en};
    @(negedge clk);
    win_we = 1'b0;
    m_en[k] = en; m_size[k] = size; m_base[k] = base;
    set_prev();
  endtask

  task automatic wr_pins(int c, int h);
    @(negedge clk);
    pin_we = 1'b1; cs_cnt = 4'(c); hi_cnt = 4'(h);
    @(negedge clk);
    pin_we = 1'b0;
    m_cs_cnt = c; m_hi_cnt = h;
    set_prev();
  endtask

  task automatic apply(logic [23:0] a, string req);
    @(negedge clk);
    addr = a;
    #1;
    chk("R6 hold before edge", cs_n, prev_cs);
    cur_addr = a;
    @(posedge clk);
    #1;
    chk({req, " cfg_idx"}, cfg_idx, exp_idx(a));
    chk({req, " cs_no"}, cs_n, exp_cs(exp_idx(a)));
    chk({req, " R8 addr_hi"}, addr_hi, exp_hi(a));
    set_prev();
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int k = 0; k < 8; k++) begin m_en[k] = 0; m_size[k] = 0; m_base[k] = '0; end
    #12;
    // R10 reset state
    chk("R10 cs_no in reset", cs_n, 8'hFF);
    chk("R10 cfg_idx in reset", cfg_idx, 0);
    chk("R10 addr_hi in reset", addr_hi, 0);
    @(negedge clk);
    rst_n = 1'b1;
    set_prev();
    apply(24'h000000, "R5 default after reset");
    apply(24'hABCDEF, "R5 R10 windows disabled");

    // R1 boundaries: 256 KB window at 0x400000
    wr_win(1, 12'h400, 6, 1'b1);
    apply(24'h400000, "R1 first byte");
    apply(24'h43FFFF, "R1 last byte");
    apply(24'h440000, "R1 just above");
    apply(24'h3FFFFF, "R1 just below");
    // R1 smallest and largest legal sizes
    wr_win(2, 12'h001, 0, 1'b1);
    apply(24'h001FFF, "R1 4KB inside");
    apply(24'h002000, "R1 4KB outside");
    wr_win(3, 12'h800, 11, 1'b1);
    apply(24'hFFFFFF, "R1 8MB top");
    apply(24'h800000, "R1 8MB bottom");
    // R2 reserved size codes
    wr_win(4, 12'h000, 12, 1'b1);
    apply(24'h000000, "R2 code 12");
    wr_win(4, 12'h000, 15, 1'b1);
    apply(24'h000100, "R2 code 15");
    // R3 disabled window
    wr_win(1, 12'h400, 6, 1'b0);
    apply(24'h410000, "R3 disabled");
    // R4 overlap priority
    wr_win(6, 12'h600, 8, 1'b1);
    wr_win(5, 12'h600, 4, 1'b1);
    apply(24'h605000, "R4 both hit, lower wins");
    apply(24'h650000, "R4 only upper hits");
    // R7 pin counts
    wr_pins(3, 8);
    apply(24'h605000, "R7 idx above count");
    apply(24'h001000, "R7 idx below count");
    wr_pins(0, 4);
    apply(24'h001000, "R7 zero pins");
    apply(24'h123456, "R7 zero pins default");
    wr_pins(12, 10);
    apply(24'h001000, "R7 reserved count");
    wr_pins(8, 3);
    apply(24'hFFFFFF, "R8 partial hi");
    wr_pins(6, 8);
    apply(24'h650000, "R7 idx 6 at count 6");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int r;
      r = int'($urandom % 10);
      if (r == 0) begin
        int k, s;
        k = 1 + int'($urandom % 7);
        s = ($urandom % 5 == 0) ? 12 + int'($urandom % 4) : int'($urandom % 12);
        wr_win(k, 12'($urandom), s, ($urandom % 4) != 0);
      end else if (r == 1) begin
        wr_pins(int'($urandom % 16), int'($urandom % 16));
      end else begin
        logic [23:0] a;
        int k;
        a = 24'($urandom);
        if ($urandom % 2 == 0) begin
          k = 1 + int'($urandom % 7);
          if (m_size[k] <= 11)
            a = {m_base[k], 12'h000} ^ (a & 24'((32'd4096 << m_size[k]) - 1));
        end
        apply(a, "R1 R4 random");
      end
    end
    report();
  end
endmodule